// File: doc/BRIEF.md
# Timer with Pulse-Width Capture

A 16-bit up-counting timer controlled through a small byte-wide register port. Software loads a reload value, picks a mode and sets the run bit. In timer mode the counter advances on every prescaled tick. On each wrap it reloads and signals an interrupt request and a wake-up. In pulse-width mode the counter waits for a chosen edge on a synchronized measurement input. It counts while the input stays at the new level. When the input returns to its starting level, the counter freezes and the run bit clears itself, so one pulse is captured per arming.

The register window has three locations. Address 0 and address 1 reach the low and high counter bytes: a write goes to the reload register, and a read returns the live count. Address 2 is the control byte. The counter bytes are written straight to the counter only while the timer is stopped. While it runs, the new reload value waits for the next wrap.

Top module: `tmr_capture`

## Requirements
- R1: After reset, reads of address 0 (count low byte), address 1 (count high byte) and address 2 (control) return 0, and irq_o and wake_o are low. In the control byte, bit 4 is run, bits 7:6 are the mode field, bit 3 is the edge select and bit 0 is the interrupt enable.
- R2: With mode 2'b10 (timer) and run set, the counter goes up by one on every clock where tick_i is high.
- R3: A tick at count 16'hFFFF loads the reload value instead of incrementing. In the next cycle irq_o (if enabled) and wake_o are high for exactly one cycle.
- R4: With the interrupt enable at 0, a wrap still pulses wake_o, but irq_o stays low.
- R5: A write to address 0 or 1 while run is 0 sets both the reload byte and the counter byte. While run is 1 it sets only the reload byte: the count goes on from its current value, and the new reload value is used at the next wrap.
- R6: In timer mode, hardware never clears the run bit, including on a wrap.
- R7: In pulse-width mode (2'b11), counting starts only on the selected edge of meas_i: rising when edge select is 1, falling when it is 0. A level that is already present when run is set, or an edge of the other polarity, starts nothing.
- R8: In pulse-width mode, a tick counts on the cycle where the starting edge is seen and on every later cycle while meas_i holds that level. When meas_i goes back, counting stops and hardware clears run.
- R9: After a capture, further edges on meas_i leave the count unchanged until software sets run again. The next pulse is then measured.
- R10: In a cycle where rd_en_i is high with address 1, the tick is ignored.
- R11: Mode values 2'b00 and 2'b01 never advance the counter, even with run set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address: 0 count low, 1 count high, 2 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i while rd_en_i is high |
| tick_i | input | 1 | Prescaled count enable |
| meas_i | input | 1 | Measurement input, already synchronized to clk_i |
| irq_o | output | 1 | Interrupt request, one-cycle pulse per wrap |
| wake_o | output | 1 | Wake-up pulse, one cycle per wrap |

## Verification
The assertions assume that meas_i is already synchronous to clk_i and that the mode field is changed only by a write to the control byte. So the counter must hold whenever no write occurs in an invalid mode or during a high-byte read. They also assume that a clear of run without a control write can only come from pulse-width completion. The stimulus drives every input on the falling clock edge. It keeps tick_i low during readback, except in the test that checks read blocking, so that reads do not disturb counts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_BAD = 2'b01,
    MODE_TMR = 2'b10,
    MODE_PW  = 2'b11
  } tmr_mode_e;

  typedef enum logic {
    PW_WAIT = 1'b0,
    PW_CNT  = 1'b1
  } pw_state_e;

  localparam int CTL_IE   = 0;
  localparam int CTL_EDGE = 3;
  localparam int CTL_ON   = 4;
  localparam int CTL_MODE = 6;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8,
  localparam int NB = CNT_W / BUS_W,
  localparam int ADDR_W = $clog2(NB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              hw_clr_on_i,
  output logic [BUS_W-1:0]  ctrl_o,
  output logic [CNT_W-1:0]  preload_o,
  output logic [NB-1:0]     cnt_ld_o
);
  import tmr_pkg::*;

  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NB);

  logic [BUS_W-1:0] ctrl_q;
  logic             ctl_wr;

  assign ctl_wr = wr_en_i && (addr_i == CTL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctl_wr) begin
      ctrl_q <= wdata_i;
    end else if (hw_clr_on_i) begin
      ctrl_q[CTL_ON] <= 1'b0;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic             sel;
    logic [BUS_W-1:0] byte_q;
    assign sel = wr_en_i && (addr_i == ADDR_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  byte_q <= '0;
      else if (sel) byte_q <= wdata_i;
    end
    assign preload_o[b*BUS_W +: BUS_W] = byte_q;
    // counter byte follows the write only while stopped
    assign cnt_ld_o[b] = sel && !ctrl_q[CTL_ON];
  end

  assign ctrl_o = ctrl_q;

  // R6: only pulse-width completion may drop run without a write
  p_hw_clear_pw_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ctrl_q[CTL_ON]) && !$past(ctl_wr)) |->
      ($past(ctrl_q[CTL_MODE +: 2]) == MODE_PW));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8,
  localparam int NB = CNT_W / BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [NB-1:0]    ld_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] preload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, ld_val;

  assign wrap_o = run_i && (cnt_q == '1);

  always_comb begin
    ld_val = cnt_q;
    for (int b = 0; b < NB; b++) begin
      if (ld_i[b]) ld_val[b*BUS_W +: BUS_W] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wrap_o)  cnt_q <= preload_i;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
    else              cnt_q <= ld_val;
  end

  assign cnt_o = cnt_q;

  p_reload_on_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == $past(preload_i)));

  p_step_by_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_hold_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && (ld_i == '0)) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_pw.sv
module tmr_pw (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic edge_sel_i,
  input  logic meas_i,
  output logic count_o,
  output logic done_o
);
  import tmr_pkg::*;

  pw_state_e st_q;
  logic      prev_q;
  logic      at_level, edge_hit;

  assign at_level = (meas_i == edge_sel_i);
  assign edge_hit = at_level && (prev_q != edge_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= meas_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= PW_WAIT;
    end else if (!armed_i) begin
      st_q <= PW_WAIT;
    end else begin
      case (st_q)
        PW_WAIT: if (edge_hit)  st_q <= PW_CNT;
        PW_CNT:  if (!at_level) st_q <= PW_WAIT;
        default: st_q <= PW_WAIT;
      endcase
    end
  end

  // the edge cycle itself is counted
  assign count_o = armed_i && (((st_q == PW_WAIT) && edge_hit) ||
                               ((st_q == PW_CNT) && at_level));
  assign done_o  = armed_i && (st_q == PW_CNT) && !at_level;

  p_start_on_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == PW_WAIT && st_q == PW_CNT) |->
      ($past(meas_i) == $past(edge_sel_i) && $past(prev_q) != $past(edge_sel_i)));

  p_done_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !count_o);
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8,
  localparam int NB = CNT_W / BUS_W,
  localparam int ADDR_W = $clog2(NB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              tick_i,
  input  logic              meas_i,
  output logic              irq_o,
  output logic              wake_o
);
  import tmr_pkg::*;

  localparam logic [ADDR_W-1:0] HI_ADDR  = ADDR_W'(NB - 1);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NB);

  logic [BUS_W-1:0] ctrl;
  logic [CNT_W-1:0] preload, cnt;
  logic [NB-1:0]    cnt_ld;
  logic             pw_count, pw_done, wrap, run, tick_ok, on, armed, rd_hi;
  tmr_mode_e        mode;
  logic             irq_q, wake_q;

  assign on      = ctrl[CTL_ON];
  assign mode    = tmr_mode_e'(ctrl[CTL_MODE +: 2]);
  assign armed   = on && (mode == MODE_PW);
  assign rd_hi   = rd_en_i && (addr_i == HI_ADDR);
  assign tick_ok = tick_i && !rd_hi;

  always_comb begin
    unique case (mode)
      MODE_TMR: run = on && tick_ok;
      MODE_PW:  run = pw_count && tick_ok;
      default:  run = 1'b0;
    endcase
  end

  tmr_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .hw_clr_on_i (pw_done),
    .ctrl_o      (ctrl),
    .preload_o   (preload),
    .cnt_ld_o    (cnt_ld)
  );

  tmr_pw u_pw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .armed_i    (armed),
    .edge_sel_i (ctrl[CTL_EDGE]),
    .meas_i     (meas_i),
    .count_o    (pw_count),
    .done_o     (pw_done)
  );

  tmr_count #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .ld_i      (cnt_ld),
    .wdata_i   (wdata_i),
    .preload_i (preload),
    .cnt_o     (cnt),
    .wrap_o    (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= wrap && ctrl[CTL_IE];
      wake_q <= wrap;
    end
  end

  assign irq_o  = irq_q;
  assign wake_o = wake_q;

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i == CTL_ADDR)   rdata_o = ctrl;
      else if (addr_i < CTL_ADDR) begin
        for (int b = 0; b < NB; b++)
          if (addr_i == ADDR_W'(b)) rdata_o = cnt[b*BUS_W +: BUS_W];
      end
    end
  end

  p_irq_implies_wake_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wake_o);

  p_invalid_mode_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode == MODE_OFF || mode == MODE_BAD) && !wr_en_i) |=> $stable(cnt));

  p_read_blocks_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi && !wr_en_i) |=> $stable(cnt));

  p_irq_needs_ie_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !ctrl[CTL_IE]) |=> !irq_o);
endmodule

// File: tb/tmr_capture_test.sv
`timescale 1ns/1ps
module tmr_capture_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0, meas = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, wake;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick),
    .meas_i(meas), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd0, lo); rd(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic tick_once;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_cnt(input logic [7:0] ctl_off, input logic [15:0] v);
    wr(2'd2, ctl_off); wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); chk("R1 count low", d, 0);
    rd(2'd1, d); chk("R1 count high", d, 0);
    rd(2'd2, d); chk("R1 control", d, 0);
    chk("R1 irq", irq, 0); chk("R1 wake", wake, 0);
  endtask

  task automatic t_timer_count;
    logic [15:0] v;
    set_cnt(8'h81, 16'h0000);
    wr(2'd2, 8'h91);
    @(negedge clk); tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    rd_cnt(v); chk("R2 count after 5 ticks", v, 16'd5);
  endtask

  task automatic t_wrap_irq;
    logic [15:0] v;
    set_cnt(8'h81, 16'hFFFD);
    wr(2'd2, 8'h91);
    tick_once; tick_once;
    chk("R3 no irq before wrap", irq, 0);
    tick_once;
    chk("R3 irq on wrap", irq, 1); chk("R3 wake on wrap", wake, 1);
    @(negedge clk);
    chk("R3 irq one cycle", irq, 0);
    rd_cnt(v); chk("R3 reload value", v, 16'hFFFD);
  endtask

  task automatic t_preload_running;
    logic [15:0] v;
    logic [7:0] d;
    wr(2'd0, 8'h10); wr(2'd1, 8'hFF);
    rd_cnt(v); chk("R5 count untouched while running", v, 16'hFFFD);
    tick_once; tick_once; tick_once;
    rd_cnt(v); chk("R5 new preload at wrap", v, 16'hFF10);
    rd(2'd2, d); chk("R6 run kept after wrap", d, 8'h91);
  endtask

  task automatic t_no_ie;
    set_cnt(8'h80, 16'hFFFF);
    wr(2'd2, 8'h90);
    tick_once;
    chk("R4 irq masked", irq, 0); chk("R4 wake still", wake, 1);
  endtask

  task automatic t_read_block;
    logic [15:0] v;
    set_cnt(8'h80, 16'h0000);
    wr(2'd2, 8'h90);
    @(negedge clk); tick = 1'b1; rd_en = 1'b1; addr = 2'd1;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk); tick = 1'b0;
    rd_cnt(v); chk("R10 high read blocks tick", v, 16'd1);
  endtask

  task automatic t_bad_modes;
    logic [15:0] v;
    set_cnt(8'h80, 16'h0000);
    wr(2'd2, 8'h50);
    @(negedge clk); tick = 1'b1; repeat (4) @(negedge clk); tick = 1'b0;
    rd_cnt(v); chk("R11 mode 01 frozen", v, 0);
    wr(2'd2, 8'h10);
    @(negedge clk); tick = 1'b1; repeat (4) @(negedge clk); tick = 1'b0;
    rd_cnt(v); chk("R11 mode 00 frozen", v, 0);
  endtask

  task automatic t_pw_rise;
    logic [15:0] v;
    logic [7:0] d;
    meas = 1'b1;
    set_cnt(8'hC9, 16'h0000);
    wr(2'd2, 8'hD9);
    @(negedge clk); tick = 1'b1; repeat (4) @(negedge clk); tick = 1'b0;
    rd_cnt(v); chk("R7 present level ignored", v, 0);
    @(negedge clk); tick = 1'b1; meas = 1'b0;
    repeat (2) @(negedge clk); meas = 1'b1;
    repeat (6) @(negedge clk); meas = 1'b0;
    repeat (3) @(negedge clk); tick = 1'b0;
    rd_cnt(v); chk("R8 rising pulse width", v, 16'd6);
    rd(2'd2, d); chk("R8 run cleared", d, 8'hC9);
    @(negedge clk); tick = 1'b1; meas = 1'b1;
    repeat (3) @(negedge clk); meas = 1'b0;
    repeat (2) @(negedge clk); tick = 1'b0;
    rd_cnt(v); chk("R9 capture held", v, 16'd6);
    set_cnt(8'hC9, 16'h0000);
    wr(2'd2, 8'hD9);
    @(negedge clk); tick = 1'b1; meas = 1'b1;
    repeat (4) @(negedge clk); meas = 1'b0;
    repeat (2) @(negedge clk); tick = 1'b0;
    rd_cnt(v); chk("R9 re-armed capture", v, 16'd4);
  endtask

  task automatic t_pw_fall;
    logic [15:0] v;
    logic [7:0] d;
    meas = 1'b1;
    set_cnt(8'hC1, 16'h0000);
    wr(2'd2, 8'hD1);
    @(negedge clk); tick = 1'b1;
    repeat (2) @(negedge clk); meas = 1'b0;
    repeat (3) @(negedge clk); meas = 1'b1;
    repeat (2) @(negedge clk); tick = 1'b0;
    rd_cnt(v); chk("R7 falling pulse width", v, 16'd3);
    rd(2'd2, d); chk("R8 run cleared falling", d, 8'hC1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_timer_count;
    t_wrap_irq;
    t_preload_running;
    t_no_ie;
    t_read_block;
    t_bad_modes;
    t_pw_rise;
    t_pw_fall;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule